// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs the multi-byte programming mode of a serial flash. A host selects the device by pulling chip select low, shifts bytes in MSB first, and deselects to end the frame. The first frame of the mode holds the opcode, a 24-bit start address and two data bytes. Every later frame holds only the opcode and two new bytes. The sequencer stores the word address, issues one program request for two bytes per accepted frame, and holds an internal busy state for a fixed number of clocks after each request. A write-disable command leaves the mode.

The program request goes to an array controller outside this block as a one-cycle strobe with the even address, the two data bytes and a per-byte enable. Bytes at or above a protection boundary are masked, so the array leaves them as they are. The array must already hold erased bytes (FFh) at the target addresses. Software can read busy from a status byte. It can also enable a ready/busy mode, in which the serial output pin shows ready whenever chip select is high.

The serial clock is handled as a one-cycle sample strobe (`sckEn`) in the system clock domain. A frame is decoded on the first clock edge that sees chip select high.

Top module: `aai_seq`

## Requirements
- R1: After reset, the write-enable flag, the mode flag, busy and ready/busy mode are all clear. A status read returns 00h, and `soOe` is 0 while `csN` is high.
- R2: A 6-byte frame with opcode ADh is accepted only while the write-enable flag is set and the sequencer is not busy. It raises `progStart` for exactly one cycle with `progAddr` equal to the start address with bit 0 cleared, `progData[7:0]` equal to the first data byte and `progData[15:8]` equal to the second. It also sets the mode flag.
- R3: An ADh frame is ignored, with no `progStart` and no flag change, when it comes without write-enable, when its byte count is wrong, or when it ends part-way through a byte.
- R4: While the mode flag is set, a 3-byte ADh frame programs the word at the previous `progAddr` plus 2. Its first data byte goes to `progData[7:0]`.
- R5: Busy is high for exactly PROG_CYCLES clocks, starting on the edge that raises `progStart`. An ADh frame that ends while busy is discarded.
- R6: While the mode flag is set, every opcode except ADh, 04h (write-disable) and 05h (status read) is ignored. For example, 80h does not leave ready/busy mode.
- R7: A 1-byte 04h frame clears both the write-enable flag and the mode flag. A busy period already running continues to its end.
- R8: After opcode 05h, the status byte is shifted out MSB first on `so`, one bit per `sckEn`, with `soOe` high. Bit 0 is busy, bit 1 is write-enable, bit 6 is the mode flag, and all other bits are 0.
- R9: Opcode 70h turns ready/busy mode on and 80h turns it off, outside the program mode. While the mode is on and `csN` is high, `soOe` is 1 and `so` is the inverse of busy.
- R10: `progByteEn[0]` is set when `progAddr` < `protBound`, and `progByteEn[1]` is set when `progAddr`+1 < `protBound`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sckEn | input | 1 | One-cycle strobe: sample `si` as the next serial bit |
| si | input | 1 | Serial data in, MSB first |
| protBound | input | ADDR_W | First protected byte address |
| so | output | 1 | Serial data out: status bits, or the ready/busy level |
| soOe | output | 1 | Output enable for `so` |
| progStart | output | 1 | One-cycle program request to the array |
| progAddr | output | ADDR_W | Even address of the word being programmed |
| progData | output | 16 | Word data, even-address byte in bits 7:0 |
| progByteEn | output | 2 | Per-byte program enable after protection |

## Verification
A frame is decoded on the clock edge that first sees `csN` high. The bench raises `csN` on a falling edge, and the program request and any flag change are visible at the next falling edge. The scoreboard monitor samples `progStart` on every falling edge and compares it against the queued expected word in that same half-cycle. Busy is measured through the ready/busy line by counting falling edges with `so` low, starting at the first falling edge after the decode edge, and the count must equal PROG_CYCLES. Status bits are sampled on the falling edge before each `sckEn` pulse: the first bit is valid right after the edge that takes in the last opcode bit, and each later bit is valid one strobe after the one before.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_AAI   = 8'hAD;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RBON  = 8'h70;
  localparam logic [7:0] OP_RBOFF = 8'h80;

  localparam int FIRST_FRAME_BYTES = 6;
  localparam int NEXT_FRAME_BYTES  = 3;

  typedef struct packed {
    logic       frameEnd;
    logic       bitsIdle;
    logic [2:0] byteCnt;
    logic [7:0] opcode;
  } aaiFrame_t;

  typedef struct packed {
    logic startWord;
    logic nextWord;
  } aaiStrobe_t;
endpackage

// File: rtl/aai_datapath.sv
module aai_datapath
  import aai_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sckEn,
  input  logic              si,
  input  logic [ADDR_W-1:0] protBound,
  input  aaiStrobe_t        strobe,
  input  logic              welFlag,
  input  logic              aaiFlag,
  input  logic              rbEnable,
  output aaiFrame_t         frame,
  output logic              busy,
  output logic              so,
  output logic              soOe,
  output logic              progStart,
  output logic [ADDR_W-1:0] progAddr,
  output logic [15:0]       progData,
  output logic [1:0]        progByteEn
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  logic [2:0]        bitCnt;
  logic [7:0]        rxShift;
  logic [2:0]        byteCnt;
  logic [7:0]        opcode;
  logic [23:0]       addrIn;
  logic [15:0]       dataPair;
  logic              csPrev;
  logic              rdMode;
  logic [7:0]        txShift;
  logic [CNT_W-1:0]  busyCnt;
  logic [ADDR_W-1:0] addrReg;

  logic              byteDone;
  logic [7:0]        byteVal;
  logic [7:0]        statusByte;
  logic [ADDR_W-1:0] nextAddr;
  logic [1:0]        nextEn;
  logic              fire;

  assign byteDone   = sckEn && !csN && (bitCnt == 3'd7);
  assign byteVal    = {rxShift[6:0], si};
  assign busy       = (busyCnt != '0);
  assign statusByte = {1'b0, aaiFlag, 4'b0000, welFlag, busy};
  assign fire       = strobe.startWord || strobe.nextWord;

  assign frame.frameEnd = csN && !csPrev;
  assign frame.bitsIdle = (bitCnt == 3'd0);
  assign frame.byteCnt  = byteCnt;
  assign frame.opcode   = opcode;

  // serial receive: bit and byte counters, field capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      byteCnt  <= '0;
      opcode   <= '0;
      addrIn   <= '0;
      dataPair <= '0;
      csPrev   <= 1'b1;
    end else begin
      csPrev <= csN;
      if (csN) begin
        bitCnt  <= '0;
        byteCnt <= '0;
      end else if (sckEn) begin
        rxShift <= byteVal;
        bitCnt  <= bitCnt + 3'd1;
        if (byteDone) begin
          if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
          if (byteCnt == 3'd0) opcode <= byteVal;
          if (byteCnt >= 3'd1 && byteCnt <= 3'd3) addrIn <= {addrIn[15:0], byteVal};
          dataPair <= {byteVal, dataPair[15:8]};
        end
      end
    end
  end

  // status response shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdMode  <= 1'b0;
      txShift <= '0;
    end else if (csN) begin
      rdMode <= 1'b0;
    end else if (byteDone && byteCnt == 3'd0 && byteVal == OP_RDSR) begin
      rdMode  <= 1'b1;
      txShift <= statusByte;
    end else if (rdMode && byteDone) begin
      txShift <= statusByte;
    end else if (rdMode && sckEn) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_comb begin
    so   = 1'b0;
    soOe = 1'b0;
    if (!csN && rdMode) begin
      so   = txShift[7];
      soOe = 1'b1;
    end else if (csN && rbEnable) begin
      so   = !busy;
      soOe = 1'b1;
    end
  end

  // word address and per-byte protection
  assign nextAddr = strobe.startWord ? {addrIn[ADDR_W-1:1], 1'b0} : (addrReg + WORD_STEP);

  for (genvar g = 0; g < 2; g++) begin : g_byteProt
    assign nextEn[g] = ((nextAddr + ADDR_W'(g)) < protBound);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg    <= '0;
      busyCnt    <= '0;
      progStart  <= 1'b0;
      progAddr   <= '0;
      progData   <= '0;
      progByteEn <= '0;
    end else begin
      progStart <= fire;
      if (fire) begin
        addrReg    <= nextAddr;
        busyCnt    <= CNT_LOAD;
        progAddr   <= nextAddr;
        progData   <= dataPair;
        progByteEn <= nextEn;
      end else if (busy) begin
        busyCnt <= busyCnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/aai_control.sv
module aai_control
  import aai_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  aaiFrame_t  frame,
  input  logic       busy,
  output aaiStrobe_t strobe,
  output logic       welFlag,
  output logic       aaiFlag,
  output logic       rbEnable
);
  logic welNext, aaiNext, rbNext;
  logic oneByte, firstLen, nextLen, decodeNow;

  assign decodeNow = frame.frameEnd && frame.bitsIdle;
  assign oneByte   = (frame.byteCnt == 3'd1);
  assign firstLen  = (frame.byteCnt == 3'(FIRST_FRAME_BYTES));
  assign nextLen   = (frame.byteCnt == 3'(NEXT_FRAME_BYTES));

  always_comb begin
    strobe  = '0;
    welNext = welFlag;
    aaiNext = aaiFlag;
    rbNext  = rbEnable;
    if (decodeNow) begin
      if (aaiFlag) begin
        if (frame.opcode == OP_AAI && nextLen && !busy) begin
          strobe.nextWord = 1'b1;
        end else if (frame.opcode == OP_WRDI && oneByte) begin
          welNext = 1'b0;
          aaiNext = 1'b0;
        end
      end else begin
        case (frame.opcode)
          OP_WREN:  if (oneByte) welNext = 1'b1;
          OP_WRDI:  if (oneByte) welNext = 1'b0;
          OP_RBON:  if (oneByte) rbNext  = 1'b1;
          OP_RBOFF: if (oneByte) rbNext  = 1'b0;
          OP_AAI: begin
            if (firstLen && welFlag && !busy) begin
              strobe.startWord = 1'b1;
              aaiNext          = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welFlag  <= 1'b0;
      aaiFlag  <= 1'b0;
      rbEnable <= 1'b0;
    end else begin
      welFlag  <= welNext;
      aaiFlag  <= aaiNext;
      rbEnable <= rbNext;
    end
  end
endmodule

// File: rtl/aai_seq.sv
module aai_seq
  import aai_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sckEn,
  input  logic              si,
  input  logic [ADDR_W-1:0] protBound,
  output logic              so,
  output logic              soOe,
  output logic              progStart,
  output logic [ADDR_W-1:0] progAddr,
  output logic [15:0]       progData,
  output logic [1:0]        progByteEn
);
  aaiFrame_t  frame;
  aaiStrobe_t strobe;
  logic       busy, welFlag, aaiFlag, rbEnable;

  aai_datapath #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sckEn(sckEn), .si(si),
    .protBound(protBound), .strobe(strobe), .welFlag(welFlag),
    .aaiFlag(aaiFlag), .rbEnable(rbEnable), .frame(frame), .busy(busy),
    .so(so), .soOe(soOe), .progStart(progStart), .progAddr(progAddr),
    .progData(progData), .progByteEn(progByteEn)
  );

  aai_control u_ctl (
    .clk(clk), .rstN(rstN), .frame(frame), .busy(busy), .strobe(strobe),
    .welFlag(welFlag), .aaiFlag(aaiFlag), .rbEnable(rbEnable)
  );
endmodule

// File: rtl/aai_seq_chk.sv
module aai_seq_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic so,
  input logic soOe,
  input logic progStart,
  input logic addrLsb,
  input logic busy,
  input logic welFlag,
  input logic aaiFlag,
  input logic rbEnable
);
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> !addrLsb);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  p_needs_wel_r3: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> $past(welFlag));

  p_idle_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (!$past(busy) && busy));

  p_wrdi_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aaiFlag) |-> !welFlag);

  p_rb_line_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csN && rbEnable) |-> (soOe && (so == !busy)));

  p_rb_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !rbEnable) |-> !soOe);
endmodule

bind aai_seq aai_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .so(so), .soOe(soOe),
  .progStart(progStart), .addrLsb(progAddr[0]), .busy(busy),
  .welFlag(welFlag), .aaiFlag(aaiFlag), .rbEnable(rbEnable)
);

// File: tb/sim_aai_seq.sv
module sim_aai_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int PROG       = 100;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [15:0]       data;
    logic [1:0]        en;
  } word_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sckEn = 1'b0;
  logic si = 1'b0;
  logic [ADDR_W-1:0] protBound = 24'h0000FF;
  logic so, soOe, progStart;
  logic [ADDR_W-1:0] progAddr;
  logic [15:0] progData;
  logic [1:0] progByteEn;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit finished = 1'b0;
  word_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aai_seq #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sckEn(sckEn), .si(si),
    .protBound(protBound), .so(so), .soOe(soOe), .progStart(progStart),
    .progAddr(progAddr), .progData(progData), .progByteEn(progByteEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && progStart === 1'b1) begin
      pulses++;
      if (expQ.size() == 0) begin
        check("R3 unexpected program request", {8'h0, progAddr}, 32'hFFFFFFFF);
      end else begin
        word_t e;
        e = expQ.pop_front();
        check("R2/R4 word address", {8'h0, progAddr}, {8'h0, e.addr});
        check("R2/R4 word data", {16'h0, progData}, {16'h0, e.data});
        check("R10 byte enables", {30'h0, progByteEn}, {30'h0, e.en});
      end
    end
  end

  task automatic sendBit(input logic b);
    @(negedge clk);
    si = b;
    sckEn = 1'b1;
    @(negedge clk);
    sckEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic startFrame();
    @(negedge clk);
    csN = 1'b0;
  endtask

  task automatic endFrame();
    @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic cmd1(input logic [7:0] op);
    startFrame();
    sendByte(op);
    endFrame();
  endtask

  task automatic aaiNext(input logic [7:0] d0, input logic [7:0] d1);
    startFrame();
    sendByte(8'hAD);
    sendByte(d0);
    sendByte(d1);
    endFrame();
  endtask

  task automatic readStatus(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    logic oeAll;
    oeAll = 1'b1;
    startFrame();
    sendByte(8'h05);
    for (int i = 7; i >= 0; i--) begin
      got[i] = so;
      oeAll = oeAll & soOe;
      sendBit(1'b0);
    end
    endFrame();
    check({tag, " status byte"}, {24'h0, got}, {24'h0, exp});
    check("R8 soOe during status", {31'h0, oeAll}, 32'h1);
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    @(negedge clk);
    while (so !== 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 soOe idle", {31'h0, soOe}, 32'h0);
    readStatus("R1 R8 reset", 8'h00);

    // R3: no write-enable
    startFrame();
    sendByte(8'hAD); sendByte(8'h00); sendByte(8'h00); sendByte(8'h10);
    sendByte(8'h11); sendByte(8'h22);
    endFrame();
    readStatus("R3 no wel", 8'h00);

    // R9: ready/busy mode on
    cmd1(8'h70);
    @(negedge clk);
    check("R9 rb oe", {31'h0, soOe}, 32'h1);
    check("R9 rb ready", {31'h0, so}, 32'h1);

    cmd1(8'h06);
    readStatus("R8 wel set", 8'h02);

    // R3: wrong length (5 bytes) and partial byte
    startFrame();
    sendByte(8'hAD); sendByte(8'h00); sendByte(8'h00); sendByte(8'h10); sendByte(8'h11);
    endFrame();
    startFrame();
    sendByte(8'hAD); sendByte(8'h00); sendByte(8'h00); sendByte(8'h10);
    sendByte(8'h11); sendByte(8'h22); sendBit(1'b1);
    endFrame();
    readStatus("R3 malformed", 8'h02);
    check("R3 no pulses", pulses, 0);

    // R2: first frame, odd start address forced even
    expQ.push_back('{addr: 24'h0000FA, data: 16'hB2A1, en: 2'b11});
    startFrame();
    sendByte(8'hAD); sendByte(8'h00); sendByte(8'h00); sendByte(8'hFB);
    sendByte(8'hA1); sendByte(8'hB2);
    endFrame();
    // R5: busy length seen on ready/busy line
    n = 0;
    @(negedge clk);
    while (so === 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R5 busy cycles", n, PROG);
    readStatus("R2 R8 mode set", 8'h42);

    // R4: next word, then a frame during busy is dropped (R5)
    expQ.push_back('{addr: 24'h0000FC, data: 16'hD4C3, en: 2'b11});
    aaiNext(8'hC3, 8'hD4);
    aaiNext(8'h11, 8'h22);
    waitIdle();
    check("R5 discard during busy", pulses, 2);

    // R10: straddling and fully protected words
    expQ.push_back('{addr: 24'h0000FE, data: 16'hF6E5, en: 2'b01});
    aaiNext(8'hE5, 8'hF6);
    waitIdle();
    expQ.push_back('{addr: 24'h000100, data: 16'h8877, en: 2'b00});
    aaiNext(8'h77, 8'h88);
    waitIdle();

    // R6: 80h ignored while in mode
    cmd1(8'h80);
    @(negedge clk);
    check("R6 rb off ignored", {31'h0, soOe}, 32'h1);
    readStatus("R6 flags kept", 8'h42);

    // R7: write-disable during busy
    expQ.push_back('{addr: 24'h000102, data: 16'hAA99, en: 2'b00});
    aaiNext(8'h99, 8'hAA);
    cmd1(8'h04);
    readStatus("R7 busy continues", 8'h01);
    waitIdle();
    readStatus("R7 flags clear", 8'h00);
    aaiNext(8'h55, 8'h66);
    repeat (4) @(negedge clk);
    check("R7 no program after exit", pulses, 5);

    // R9: ready/busy mode off
    cmd1(8'h80);
    @(negedge clk);
    check("R9 rb off", {31'h0, soOe}, 32'h0);
    check("R2 R4 queue drained", expQ.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule